// File: doc/BRIEF.md
# Multichannel Threshold Watchdog Sequencer

This block watches data against a shared upper and lower limit and keeps sticky out-of-range flags for each of four channels. It works in one of two source modes. In final-data mode, each completed conversion result arrives as a 24-bit signed word with a one-cycle strobe. The block compares that word against the full 24-bit limits, and any violation lands in the channel 0 flags. In channel mode, up to four fast watchdog filters each deliver 16-bit signed samples. Only channels enabled in a 4-bit mask are watched. Each of those samples is compared against the upper 16 bits of the limits.

In channel mode a captured sample waits in a per-channel pending register. A single shared comparator services one pending channel per clock, taking the lowest-numbered one first. A newer sample on a channel replaces one that has not been serviced yet. Channel monitoring does not depend on the final-data strobe.

A three-state machine sequences the work. `S_FINAL` compares final results. `S_CHAN` captures channel samples and grants the lowest pending masked channel. `S_FLUSH` lasts one cycle and discards all pending samples. The transitions are:
- `S_FINAL -> S_FLUSH` when the source select goes to 1.
- `S_CHAN -> S_FLUSH` when the source select goes to 0.
- `S_FLUSH -> S_CHAN` or `S_FLUSH -> S_FINAL`, following the source select.
- Every state holds while the source select matches it.

Top module: `thr_watch_seq`

## Requirements
- R1: While reset is low, and after it is released, all high and low flags are 0 and the block is in final-data mode.
- R2: In final-data mode, when `fin_valid` is 1 at a rising edge, that edge sets `flag_hi[0]` if the signed 24-bit `fin_data` is strictly greater than the signed `thr_hi`. It sets `flag_lo[0]` if `fin_data` is strictly less than the signed `thr_lo`. Channel inputs do not affect any flag in this mode.
- R3: In channel mode, a masked channel's 16-bit signed sample is captured at the edge where its valid bit is 1. It is compared against `thr_hi[23:8]` and `thr_lo[23:8]` as signed 16-bit values. Threshold bits [7:0] have no effect. A violation sets that channel's flag one edge after capture when no other channel is waiting.
- R4: A sample equal to a threshold sets no flag, in either mode.
- R5: Exactly one pending channel is compared per clock, the lowest-numbered pending channel first. When all four are captured at the same edge, the flags of channels 0, 1, 2 and 3 appear on the 1st, 2nd, 3rd and 4th edges after capture.
- R6: A channel whose `ch_mask` bit is 0 is not captured. Clearing a mask bit drops that channel's pending sample at the next edge.
- R7: A new sample on a channel that is still pending replaces the older one, and only the newer value is compared.
- R8: Flags are sticky. A 1 on `clr_hi[i]` or `clr_lo[i]` clears the matching flag at the next edge. A clear and a set in the same cycle leave the flag set.
- R9: A change of `src_sel` passes through a single-cycle flush that discards all pending channel samples. `fin_valid` has no effect while in channel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 1 | 0 selects final-data mode, 1 selects channel mode |
| ch_mask | input | 4 | Channel enable, bit i watches channel i |
| thr_hi | input | 24 | Signed upper limit |
| thr_lo | input | 24 | Signed lower limit |
| fin_data | input | 24 | Signed final conversion result |
| fin_valid | input | 1 | One-cycle strobe for `fin_data` |
| ch_data | input | 64 | Channel samples, channel i in bits [16i+15:16i] |
| ch_valid | input | 4 | Per-channel sample strobe |
| clr_hi | input | 4 | Write-1 clear for high flags |
| clr_lo | input | 4 | Write-1 clear for low flags |
| flag_hi | output | 4 | Sticky above-limit flags |
| flag_lo | output | 4 | Sticky below-limit flags |

## Verification
The comparator's exclusivity check assumes the upper limit is never below the lower limit. The bench therefore keeps both limits fixed and ordered, with the upper one positive and the lower one negative. Low bytes are chosen so that a 24-bit comparison would differ from the 16-bit one. The masked-channel check assumes the mask is steady or only narrows while samples are pending. Every mask change in the stimulus is made at a falling edge, before the affected grant.

// File: rtl/twd_pkg.sv
package twd_pkg;
    typedef enum logic [1:0] {
        S_FINAL = 2'd0,
        S_FLUSH = 2'd1,
        S_CHAN  = 2'd2
    } twd_state_e;
endpackage

// File: rtl/twd_cmp.sv
module twd_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] smp,
    input  logic [W-1:0] lim_hi,
    input  logic [W-1:0] lim_lo,
    output logic         above,
    output logic         below
);
    always_comb begin
        above = $signed(smp) > $signed(lim_hi);
        below = $signed(smp) < $signed(lim_lo);
    end

    // R4: with ordered limits a sample cannot violate both
    always_comb begin
        if ($signed(lim_hi) >= $signed(lim_lo)) begin
            a_r4_exclusive: assert (!(above && below))
                else $error("a_r4_exclusive");
        end
    end
endmodule

// File: rtl/twd_seq_fsm.sv
module twd_seq_fsm
    import twd_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           src_sel,
    input  logic [NCH-1:0] pend_ok,
    output twd_state_e     state_q,
    output logic [NCH-1:0] grant,
    output logic           cap_en,
    output logic           fin_en,
    output logic           flush
);
    twd_state_e state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_FINAL;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_FINAL: if (src_sel)  state_n = S_FLUSH;
            S_CHAN:  if (!src_sel) state_n = S_FLUSH;
            S_FLUSH: state_n = src_sel ? S_CHAN : S_FINAL;
            default: state_n = S_FINAL;
        endcase
    end

    always_comb begin
        grant  = '0;
        cap_en = 1'b0;
        fin_en = 1'b0;
        flush  = 1'b0;
        unique case (state_q)
            S_FINAL: fin_en = 1'b1;
            S_FLUSH: flush  = 1'b1;
            S_CHAN: begin
                cap_en = src_sel;
                grant  = pend_ok & (~pend_ok + 1'b1);
            end
            default: ;
        endcase
    end

    a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant))
        else $error("a_r5_single_grant");

    a_r9_flush_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FLUSH) |=> (state_q != S_FLUSH))
        else $error("a_r9_flush_once");

    a_r9_enter_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FINAL && src_sel) |=> (state_q == S_FLUSH))
        else $error("a_r9_enter_flush");
endmodule

// File: rtl/twd_pend_bank.sv
module twd_pend_bank #(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    cap,
    input  logic [NCH*CW-1:0] ch_data,
    input  logic [NCH-1:0]    grant,
    input  logic [NCH-1:0]    mask,
    input  logic              flush,
    output logic [NCH-1:0]    pend,
    output logic [CW-1:0]     sel_data
);
    logic          pend_r [NCH];
    logic [CW-1:0] data_r [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_r[i] <= 1'b0;
                data_r[i] <= '0;
            end else begin
                if (flush || !mask[i]) pend_r[i] <= 1'b0;
                else if (cap[i])       pend_r[i] <= 1'b1;
                else if (grant[i])     pend_r[i] <= 1'b0;
                if (cap[i]) data_r[i] <= ch_data[i*CW +: CW];
            end
        end
        assign pend[i] = pend_r[i];

        a_r7_cap_pends: assert property (@(posedge clk) disable iff (!rst_n)
            (cap[i] && mask[i] && !flush) |=> pend_r[i])
            else $error("a_r7_cap_pends");

        a_r6_unmasked_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !mask[i] |=> !pend_r[i])
            else $error("a_r6_unmasked_idle");
    end

    always_comb begin
        sel_data = '0;
        for (int k = 0; k < NCH; k++) begin
            if (grant[k]) sel_data = sel_data | data_r[k];
        end
    end

    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (pend == '0))
        else $error("a_r9_flush_clears");
endmodule

// File: rtl/thr_watch_seq.sv
module thr_watch_seq
    import twd_pkg::*;
#(
    parameter int NCH = 4,
    parameter int TW  = 24,
    parameter int CW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_sel,
    input  logic [NCH-1:0]    ch_mask,
    input  logic [TW-1:0]     thr_hi,
    input  logic [TW-1:0]     thr_lo,
    input  logic [TW-1:0]     fin_data,
    input  logic              fin_valid,
    input  logic [NCH*CW-1:0] ch_data,
    input  logic [NCH-1:0]    ch_valid,
    input  logic [NCH-1:0]    clr_hi,
    input  logic [NCH-1:0]    clr_lo,
    output logic [NCH-1:0]    flag_hi,
    output logic [NCH-1:0]    flag_lo
);
    twd_state_e     state_q;
    logic [NCH-1:0] grant, pend, cap, set_hi, set_lo;
    logic [NCH-1:0] flag_hi_q, flag_lo_q;
    logic           cap_en, fin_en, flush;
    logic [CW-1:0]  sel_data;
    logic           c_above, c_below, f_above, f_below;

    assign cap = ch_valid & ch_mask & {NCH{cap_en}};

    twd_seq_fsm #(.NCH(NCH)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_sel (src_sel),
        .pend_ok (pend & ch_mask),
        .state_q (state_q),
        .grant   (grant),
        .cap_en  (cap_en),
        .fin_en  (fin_en),
        .flush   (flush)
    );

    twd_pend_bank #(.NCH(NCH), .CW(CW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .ch_data  (ch_data),
        .grant    (grant),
        .mask     (ch_mask),
        .flush    (flush),
        .pend     (pend),
        .sel_data (sel_data)
    );

    twd_cmp #(.W(CW)) u_cmp_ch (
        .smp    (sel_data),
        .lim_hi (thr_hi[TW-1 -: CW]),
        .lim_lo (thr_lo[TW-1 -: CW]),
        .above  (c_above),
        .below  (c_below)
    );

    twd_cmp #(.W(TW)) u_cmp_fin (
        .smp    (fin_data),
        .lim_hi (thr_hi),
        .lim_lo (thr_lo),
        .above  (f_above),
        .below  (f_below)
    );

    always_comb begin
        set_hi = grant & {NCH{c_above}};
        set_lo = grant & {NCH{c_below}};
        if (fin_en && fin_valid) begin
            set_hi[0] = set_hi[0] | f_above;
            set_lo[0] = set_lo[0] | f_below;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_hi_q <= '0;
            flag_lo_q <= '0;
        end else begin
            flag_hi_q <= (flag_hi_q & ~clr_hi) | set_hi;
            flag_lo_q <= (flag_lo_q & ~clr_lo) | set_lo;
        end
    end

    assign flag_hi = flag_hi_q;
    assign flag_lo = flag_lo_q;

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        a_r8_sticky_hi: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_hi_q[i] && !clr_hi[i]) |=> flag_hi_q[i])
            else $error("a_r8_sticky_hi");
        a_r8_sticky_lo: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_lo_q[i] && !clr_lo[i]) |=> flag_lo_q[i])
            else $error("a_r8_sticky_lo");
    end

    a_r2_final_ch0_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FINAL) |=> (((flag_hi_q & ~$past(flag_hi_q)) >> 1) == '0))
        else $error("a_r2_final_ch0_only");

    a_r6_masked_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHAN) |=> ((flag_hi_q & ~$past(flag_hi_q) & ~$past(ch_mask)) == '0))
        else $error("a_r6_masked_only");

    a_r1_reset_final: assert property (@(posedge clk)
        !rst_n |=> (state_q == S_FINAL && flag_hi_q == '0 && flag_lo_q == '0))
        else $error("a_r1_reset_final");
endmodule

// File: tb/thr_watch_seq_tb_top.sv
module thr_watch_seq_tb_top;
    localparam int NCH  = 4;
    localparam int CW   = 16;
    localparam int HI16 = 100;
    localparam int LO16 = -100;
    localparam int HI24 = HI16 * 256 + 255;
    localparam int LO24 = LO16 * 256;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              src_sel;
    logic [NCH-1:0]    ch_mask;
    logic [23:0]       thr_hi, thr_lo, fin_data;
    logic              fin_valid;
    logic [NCH*CW-1:0] ch_data;
    logic [NCH-1:0]    ch_valid, clr_hi, clr_lo;
    logic [NCH-1:0]    flag_hi, flag_lo;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    thr_watch_seq dut_i (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ch_mask(ch_mask),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .fin_data(fin_data),
        .fin_valid(fin_valid), .ch_data(ch_data), .ch_valid(ch_valid),
        .clr_hi(clr_hi), .clr_lo(clr_lo), .flag_hi(flag_hi), .flag_lo(flag_lo)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk); clr_hi = '1; clr_lo = '1;
        @(negedge clk); clr_hi = '0; clr_lo = '0;
    endtask

    task automatic send_fin(input int v);
        @(negedge clk); fin_data = v[23:0]; fin_valid = 1'b1;
        @(negedge clk); fin_valid = 1'b0;
    endtask

    task automatic send_ch(input int ch, input int v);
        @(negedge clk); ch_data[ch*CW +: CW] = v[15:0]; ch_valid[ch] = 1'b1;
        @(negedge clk); ch_valid = '0;
        @(negedge clk);
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk); src_sel = m;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; src_sel = 1'b0; ch_mask = '0; fin_valid = 1'b0;
        fin_data = '0; ch_data = '0; ch_valid = '0; clr_hi = '0; clr_lo = '0;
        thr_hi = {16'(HI16), 8'hFF};
        thr_lo = {16'(LO16), 8'h00};
        repeat (3) @(negedge clk);
        check("R1 hi in reset", flag_hi, 4'b0);
        check("R1 lo in reset", flag_lo, 4'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 hi after reset", flag_hi, 4'b0);

        // R2 / R4: final-data sweep around both 24-bit limits
        for (int d = -2; d <= 2; d++) begin
            for (int s = 0; s < 2; s++) begin
                int v;
                v = (s == 0 ? HI24 : LO24) + d;
                clear_all();
                send_fin(v);
                check("R2/R4 final hi", flag_hi, {3'b0, v > HI24});
                check("R2/R4 final lo", flag_lo, {3'b0, v < LO24});
            end
        end
        // R2: channel inputs ignored in final mode
        clear_all();
        ch_mask = '1;
        send_ch(1, 30000);
        send_ch(2, -30000);
        check("R2 ch ignored hi", flag_hi, 4'b0);
        check("R2 ch ignored lo", flag_lo, 4'b0);

        // R3 / R4 / R6: per-channel sweep in channel mode
        set_mode(1'b1);
        for (int ch = 0; ch < NCH; ch++) begin
            ch_mask = 4'(1 << ch);
            for (int d = -2; d <= 2; d++) begin
                for (int s = 0; s < 2; s++) begin
                    int v;
                    logic [3:0] eh, el;
                    v = (s == 0 ? HI16 : LO16) + d;
                    eh = (v > HI16) ? 4'(1 << ch) : 4'b0;
                    el = (v < LO16) ? 4'(1 << ch) : 4'b0;
                    clear_all();
                    send_ch(ch, v);
                    check("R3/R4 chan hi", flag_hi, eh);
                    check("R3/R4 chan lo", flag_lo, el);
                end
            end
            clear_all();
            send_ch((ch + 1) % NCH, 500);
            check("R6 unmasked ignored", flag_hi, 4'b0);
        end

        // R5: simultaneous requests, lowest first
        ch_mask = '1;
        clear_all();
        @(negedge clk); ch_valid = '1;
        for (int c = 0; c < NCH; c++) ch_data[c*CW +: CW] = 16'd200;
        @(negedge clk); ch_valid = '0;
        check("R5 before service", flag_hi, 4'b0000);
        for (int k = 1; k <= NCH; k++) begin
            @(negedge clk);
            check("R5 order", flag_hi, 4'((1 << k) - 1));
        end

        // R7: overwrite a pending sample
        clear_all();
        @(negedge clk); ch_valid = '1;
        for (int c = 0; c < NCH; c++) ch_data[c*CW +: CW] = 16'd200;
        @(negedge clk); ch_valid = 4'b1000; ch_data[3*CW +: CW] = 16'd0;
        @(negedge clk); ch_valid = '0;
        repeat (4) @(negedge clk);
        check("R7 overwrite hi", flag_hi, 4'b0111);
        check("R7 overwrite lo", flag_lo, 4'b0000);

        // R6: narrowing the mask drops a pending sample
        clear_all();
        @(negedge clk); ch_valid = 4'b0011;
        ch_data[0 +: CW] = 16'd300; ch_data[CW +: CW] = 16'd300;
        @(negedge clk); ch_valid = '0; ch_mask = 4'b0001;
        repeat (3) @(negedge clk);
        check("R6 mask drop", flag_hi, 4'b0001);
        ch_mask = '1;
        repeat (3) @(negedge clk);
        check("R6 mask restore", flag_hi, 4'b0001);

        // R8: set wins over clear, sticky, then clear
        clear_all();
        @(negedge clk); ch_valid = 4'b0001; ch_data[0 +: CW] = 16'd400;
        @(negedge clk); ch_valid = '0; clr_hi = 4'b0001;
        @(negedge clk); clr_hi = '0;
        check("R8 set wins", flag_hi, 4'b0001);
        repeat (5) @(negedge clk);
        check("R8 sticky", flag_hi, 4'b0001);
        @(negedge clk); clr_lo = 4'b0001;
        @(negedge clk); clr_lo = '0;
        check("R8 other clear", flag_hi, 4'b0001);
        @(negedge clk); clr_hi = 4'b0001;
        @(negedge clk); clr_hi = '0;
        check("R8 cleared", flag_hi, 4'b0000);

        // R9: fin_valid ignored in channel mode
        send_fin(HI24 + 1000);
        check("R9 fin ignored hi", flag_hi, 4'b0);
        send_fin(LO24 - 1000);
        check("R9 fin ignored lo", flag_lo, 4'b0);

        // R9: mode change flushes pending samples
        clear_all();
        @(negedge clk); ch_valid = 4'b0011;
        ch_data[0 +: CW] = 16'd300; ch_data[CW +: CW] = 16'd300;
        @(negedge clk); ch_valid = '0; src_sel = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 flush discards", flag_hi, 4'b0001);
        clear_all();
        send_fin(HI24 + 1);
        check("R9 final after flush", flag_hi, 4'b0001);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule